// File: doc/BRIEF.md
# Vectored Nested Priority Interrupt Controller

This block collects up to 32 interrupt requests and presents a single interrupt line to a processor. Each source has a mode register, which holds a 3-bit priority and a sense type, and a vector register that software loads with any value it likes. Among the sources that are pending, enabled and of higher priority than the level now being serviced, the controller picks a winner. Whenever a winner exists, it raises `irq_o`.

The processor services an interrupt by reading the acknowledge register. That read returns the winner's vector and pushes the winner's priority and source number onto an 8-entry nesting stack. The same read clears the winner's latched edge. Each write to the end-of-interrupt register pops one stack entry, and the value written has no effect. When no source qualifies, the acknowledge read returns a programmable spurious value and leaves the stack unchanged. Software sets and clears enable bits, and clears latched edges, through three bitmask command registers; only the bits written as 1 take effect.

All registers sit on a simple word-addressed bus. The upper two address bits select the region: 0 is mode, 1 is vector, 2 is control. The lower five bits select the source or the control register. Read data is combinational and side effects take place at the clock edge. Source inputs pass through a two-flop synchroniser before sense detection.

Top module: `vnic_top`

## Requirements
- R1: After reset, `irq_o` is 0, the mask reads 0, the status reads 0 and an acknowledge read returns the reset value of the spurious register (0).
- R2: Writing control offset 3 sets the mask bits written as 1, and writing offset 4 clears them. No other mask bit changes. The mask reads back at offset 2.
- R3: The qualifying source with the highest priority wins, where priority is mode bits [2:0] and 7 is highest. On equal priority, the lowest source number wins.
- R4: An acknowledge read (control offset 0) returns the winner's vector. Afterwards the status register (offset 1) reads the winner's source number, and `irq_o` is 0 in the cycle after the read.
- R5: While the stack is not empty, a source can interrupt only if its priority is strictly greater than the priority on top of the stack. A higher source preempts the current one; an equal one waits.
- R6: A write to the end-of-interrupt register (offset 6) pops the innermost entry whatever data is written. After the pop, status reads the next outer source.
- R7: An acknowledge read with no qualifying source returns the spurious register (offset 7). Status then reads 0 and the stack is left as it was.
- R8: Sense code 01 in mode bits [5:4] (rising edge) latches a one-cycle pulse until it is acknowledged. The acknowledge clears the latch.
- R9: Writing control offset 5 clears the latched edges of the sources whose bits are written as 1.
- R10: Sense code 00 (high level) keeps a source pending while its input stays high. That source interrupts again after its end-of-interrupt write.
- R11: Sense codes 10 (low level) and 11 (falling edge) are accepted only on external sources, which are 28 to 31 by default. A write of these codes to any other source leaves its sense field unchanged but still updates the priority.
- R12: Eight end-of-interrupt writes empty the stack from any state, including a full 8-deep nesting. After them, status reads 0 and `irq_o` can assert again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 32 | Asynchronous interrupt request inputs |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 7 | Word address: region in [6:5], index in [4:0] |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the access |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A corrupted nesting stack shows first as a wrong status value or a missing `irq_o` after the next end-of-interrupt write. Filling the stack to eight levels and then draining it exposes count and index faults within a few cycles. An arbiter that breaks ties wrongly, or that ignores the current level, returns the wrong vector on the very next acknowledge read. An edge latch that is not cleared shows as `irq_o` reasserting two cycles after the end-of-interrupt write.

// File: rtl/vnic_pkg.sv
// Shared encodings for the vectored nested interrupt controller.
// Assumes a word-addressed bus whose top two address bits select the region.
package vnic_pkg;

    // Sense types held in mode bits [5:4]; bit 1 set means active-low polarity
    typedef enum logic [1:0] {
        SENSE_HI   = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_LO   = 2'b10,
        SENSE_FALL = 2'b11
    } sense_e;

    // Address regions
    localparam logic [1:0] RGN_MODE = 2'd0;
    localparam logic [1:0] RGN_VEC  = 2'd1;
    localparam logic [1:0] RGN_CTL  = 2'd2;

    // Control register offsets within RGN_CTL
    localparam int CTL_ACK  = 0;
    localparam int CTL_STAT = 1;
    localparam int CTL_MASK = 2;
    localparam int CTL_EN   = 3;
    localparam int CTL_DIS  = 4;
    localparam int CTL_CLR  = 5;
    localparam int CTL_EOI  = 6;
    localparam int CTL_SPUR = 7;

    // Mode field position of the sense code
    localparam int MODE_SENSE_LSB = 4;

endpackage

// File: rtl/vnic_src_sense.sv
// One source front end: two-flop synchroniser, polarity fold, edge latch.
// Assumes raw_i is asynchronous. pend_o is the level for level senses and
// the latched edge for edge senses. clr_i drops the latch; a new edge in
// the same cycle wins over the clear.
module vnic_src_sense (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_i,
    input  vnic_pkg::sense_e sense_i,
    input  logic            clr_i,
    output logic            pend_o
);
    logic sync1_q, sync2_q, prev_q, edge_q;
    logic act_now, act_prev, edge_det;

    // Synchronise the input and keep one cycle of history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= raw_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    // Fold polarity so that 1 always means active
    always_comb begin
        act_now  = sync2_q ^ sense_i[1];
        act_prev = prev_q  ^ sense_i[1];
        edge_det = act_now & ~act_prev;
    end

    // Latch detected edges until cleared
    always_ff @(posedge clk) begin
        if (!rst_n) edge_q <= 1'b0;
        else        edge_q <= (edge_q & ~clr_i) | edge_det;
    end

    // Select level or latched edge as the pending state
    always_comb pend_o = sense_i[0] ? edge_q : act_now;

endmodule

// File: rtl/vnic_arbiter.sv
// Priority selection: highest priority among requests above the current
// level; ties go to the lowest index. Purely combinational.
// Assumes lvl_any_i is 0 when nothing is in service (every priority qualifies).
module vnic_arbiter #(
    parameter int N_SRC  = 32,
    parameter int PRIO_W = 3,
    localparam int IW    = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]        req_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    input  logic                    lvl_any_i,
    input  logic [PRIO_W-1:0]       lvl_top_i,
    output logic                    win_valid_o,
    output logic [IW-1:0]           win_idx_o,
    output logic [PRIO_W-1:0]       win_prio_o
);
    // Linear scan: strict greater-than keeps the earliest index on ties
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        win_prio_o  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req_i[i]
                && (!lvl_any_i || prio_i[i*PRIO_W +: PRIO_W] > lvl_top_i)
                && (!win_valid_o || prio_i[i*PRIO_W +: PRIO_W] > win_prio_o)) begin
                win_valid_o = 1'b1;
                win_idx_o   = IW'(i);
                win_prio_o  = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

    // R3: a reported winner must be an actual request
    always_comb begin
        if (win_valid_o) begin
            win_req_chk: assert (req_i[win_idx_o]);
        end
    end

endmodule

// File: rtl/vnic_nest_stack.sv
// Nesting stack of (priority, source) pairs for interrupts in service.
// Assumes push and pop never occur in the same cycle; a pop when empty is ignored.
module vnic_nest_stack #(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3,
    parameter int IW     = 5,
    localparam int SW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [PRIO_W-1:0] push_prio_i,
    input  logic [IW-1:0]     push_idx_i,
    input  logic              pop_i,
    output logic              nonempty_o,
    output logic [PRIO_W-1:0] top_prio_o,
    output logic [IW-1:0]     top_idx_o
);
    logic [PRIO_W-1:0] prio_mem [DEPTH];
    logic [IW-1:0]     idx_mem  [DEPTH];
    logic [CW-1:0]     cnt_q;
    logic [SW-1:0]     top_sel;

    // Entry storage, written at the current depth on push
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                prio_mem[k] <= '0;
                idx_mem[k]  <= '0;
            end
        end else if (push_i && cnt_q < CW'(DEPTH)) begin
            prio_mem[SW'(cnt_q)] <= push_prio_i;
            idx_mem[SW'(cnt_q)]  <= push_idx_i;
        end
    end

    // Depth counter
    always_ff @(posedge clk) begin
        if (!rst_n)                             cnt_q <= '0;
        else if (push_i && cnt_q < CW'(DEPTH))  cnt_q <= cnt_q + CW'(1);
        else if (pop_i && cnt_q != '0)          cnt_q <= cnt_q - CW'(1);
    end

    // Top-of-stack view
    always_comb begin
        top_sel    = SW'(cnt_q - CW'(1));
        nonempty_o = (cnt_q != '0);
        top_prio_o = prio_mem[top_sel];
        top_idx_o  = idx_mem[top_sel];
    end

    // R5
    // no_overflow_chk: strict priority ordering must bound the nesting depth
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (cnt_q < CW'(DEPTH)));

    // R6
    eoi_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/vnic_top.sv
// Vectored nested priority interrupt controller, top level.
// Holds the register file, decodes the bus, and joins the source front
// ends, arbiter and nesting stack. Assumes NUM_SRC is a power of two no
// larger than DATA_W and at least 8, and single-cycle bus accesses.
module vnic_top #(
    parameter int                 NUM_SRC    = 32,
    parameter int                 PRIO_W     = 3,
    parameter int                 NEST_DEPTH = 8,
    parameter int                 DATA_W     = 32,
    parameter logic [NUM_SRC-1:0] EXT_SRC    = 32'hF000_0000,
    parameter logic [DATA_W-1:0]  SPUR_INIT  = '0,
    localparam int                IW         = $clog2(NUM_SRC),
    localparam int                ADDR_W     = IW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_en_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               irq_o
);
    import vnic_pkg::*;

    // Register state
    logic [PRIO_W-1:0]  mode_prio  [NUM_SRC];
    sense_e             mode_sense [NUM_SRC];
    logic [DATA_W-1:0]  vec_q      [NUM_SRC];
    logic [NUM_SRC-1:0] mask_q;
    logic [DATA_W-1:0]  spur_q;
    logic               spur_flag_q;
    logic               irq_q;

    // Decode
    logic [1:0]         rgn;
    logic [IW-1:0]      idx;
    logic               wr, rd;
    logic               wr_mode, wr_vec, wr_en, wr_dis, wr_clr, wr_eoi, wr_spur;
    logic               ack, ack_hit;
    sense_e             new_sense;

    // Datapath links
    logic [NUM_SRC-1:0]        pend, req, clr_vec;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic                      win_valid;
    logic [IW-1:0]             win_idx;
    logic [PRIO_W-1:0]         win_prio;
    logic                      stk_any;
    logic [PRIO_W-1:0]         stk_prio;
    logic [IW-1:0]             stk_idx;

    // Address and strobe decode
    always_comb begin
        rgn       = bus_addr_i[ADDR_W-1 -: 2];
        idx       = bus_addr_i[IW-1:0];
        wr        = bus_en_i & bus_we_i;
        rd        = bus_en_i & ~bus_we_i;
        wr_mode   = wr && rgn == RGN_MODE;
        wr_vec    = wr && rgn == RGN_VEC;
        wr_en     = wr && rgn == RGN_CTL && idx == IW'(CTL_EN);
        wr_dis    = wr && rgn == RGN_CTL && idx == IW'(CTL_DIS);
        wr_clr    = wr && rgn == RGN_CTL && idx == IW'(CTL_CLR);
        wr_eoi    = wr && rgn == RGN_CTL && idx == IW'(CTL_EOI);
        wr_spur   = wr && rgn == RGN_CTL && idx == IW'(CTL_SPUR);
        ack       = rd && rgn == RGN_CTL && idx == IW'(CTL_ACK);
        ack_hit   = ack & win_valid;
        new_sense = sense_e'(bus_wdata_i[MODE_SENSE_LSB +: 2]);
    end

    // Mode registers; active-low senses only land on external sources
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_SRC; k++) begin
                mode_prio[k]  <= '0;
                mode_sense[k] <= SENSE_HI;
            end
        end else if (wr_mode) begin
            mode_prio[idx] <= bus_wdata_i[PRIO_W-1:0];
            if (!new_sense[1] || EXT_SRC[idx]) mode_sense[idx] <= new_sense;
        end
    end

    // Vector registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_SRC; k++) vec_q[k] <= '0;
        end else if (wr_vec) begin
            vec_q[idx] <= bus_wdata_i;
        end
    end

    // Enable mask: set and clear commands touch only bits written as 1
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '0;
        else if (wr_en)  mask_q <= mask_q | bus_wdata_i[NUM_SRC-1:0];
        else if (wr_dis) mask_q <= mask_q & ~bus_wdata_i[NUM_SRC-1:0];
    end

    // Spurious vector register
    always_ff @(posedge clk) begin
        if (!rst_n)       spur_q <= SPUR_INIT;
        else if (wr_spur) spur_q <= bus_wdata_i;
    end

    // Marks that the latest acknowledge found nothing
    always_ff @(posedge clk) begin
        if (!rst_n)      spur_flag_q <= 1'b0;
        else if (ack)    spur_flag_q <= ~win_valid;
        else if (wr_eoi) spur_flag_q <= 1'b0;
    end

    // Interrupt output, forced low in the cycle after an acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)   irq_q <= 1'b0;
        else if (ack) irq_q <= 1'b0;
        else          irq_q <= win_valid;
    end
    assign irq_o = irq_q;

    // Edge clears from the clear command and from the winning acknowledge
    always_comb begin
        clr_vec = wr_clr ? bus_wdata_i[NUM_SRC-1:0] : '0;
        if (ack_hit) clr_vec[win_idx] = 1'b1;
        req = pend & mask_q;
    end

    // Per-source front ends and the flattened priority vector
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        vnic_src_sense u_sense (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (src_i[g]),
            .sense_i (mode_sense[g]),
            .clr_i   (clr_vec[g]),
            .pend_o  (pend[g])
        );
        assign prio_flat[g*PRIO_W +: PRIO_W] = mode_prio[g];
    end

    vnic_arbiter #(
        .N_SRC  (NUM_SRC),
        .PRIO_W (PRIO_W)
    ) u_arb (
        .req_i       (req),
        .prio_i      (prio_flat),
        .lvl_any_i   (stk_any),
        .lvl_top_i   (stk_prio),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx),
        .win_prio_o  (win_prio)
    );

    vnic_nest_stack #(
        .DEPTH  (NEST_DEPTH),
        .PRIO_W (PRIO_W),
        .IW     (IW)
    ) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (ack_hit),
        .push_prio_i (win_prio),
        .push_idx_i  (win_idx),
        .pop_i       (wr_eoi),
        .nonempty_o  (stk_any),
        .top_prio_o  (stk_prio),
        .top_idx_o   (stk_idx)
    );

    // Read multiplexer
    always_comb begin
        bus_rdata_o = '0;
        if (rd) begin
            unique case (rgn)
                RGN_MODE: begin
                    bus_rdata_o[PRIO_W-1:0]           = mode_prio[idx];
                    bus_rdata_o[MODE_SENSE_LSB +: 2]  = mode_sense[idx];
                end
                RGN_VEC: bus_rdata_o = vec_q[idx];
                RGN_CTL: begin
                    if (idx == IW'(CTL_ACK))
                        bus_rdata_o = win_valid ? vec_q[win_idx] : spur_q;
                    else if (idx == IW'(CTL_STAT))
                        bus_rdata_o = (spur_flag_q || !stk_any) ? '0 : DATA_W'(stk_idx);
                    else if (idx == IW'(CTL_MASK))
                        bus_rdata_o = DATA_W'(mask_q);
                    else if (idx == IW'(CTL_SPUR))
                        bus_rdata_o = spur_q;
                end
                default: bus_rdata_o = '0;
            endcase
        end
    end

    // R4
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !irq_o);

    // R2
    en_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mask_q & $past(bus_wdata_i[NUM_SRC-1:0])) == $past(bus_wdata_i[NUM_SRC-1:0])));

    // R2
    dis_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dis |=> ((mask_q & $past(bus_wdata_i[NUM_SRC-1:0])) == '0));

    // R7
    spur_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !win_valid) |=> $stable(stk_any) && $stable(stk_prio));

endmodule

// File: tb/sim_vnic_top.sv
module sim_vnic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq;
    int          n_chk = 0, n_err = 0;
    bit          done = 0;

    localparam int A_ACK = 64, A_STAT = 65, A_MASK = 66, A_EN = 67,
                   A_DIS = 68, A_CLR = 69, A_EOI = 70, A_SPUR = 71;
    localparam logic [31:0] SPV = 32'h0000_DEAD;

    always #4 clk = ~clk;

    vnic_top u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_en_i(bus_en),
        .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = 7'(a); bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = 7'(a);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cleanup();
        src = '0;
        idle(6);
        wr(A_DIS, 32'hFFFF_FFFF);
        wr(A_CLR, 32'hFFFF_FFFF);
        for (int k = 0; k < 8; k++) wr(A_EOI, 32'h0);
        idle(3);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(A_MASK, d); chk("R1 mask", d, 32'h0);
        rd(A_STAT, d); chk("R1 status", d, 32'h0);
        rd(A_ACK, d);  chk("R1 ack spurious", d, 32'h0);
        for (int k = 0; k < 32; k++) wr(32 + k, 32'h100 + k);
        wr(A_SPUR, SPV);
        rd(32 + 5, d); chk("R4 vector readback", d, 32'h105);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(A_EN, 32'h0000_00F0);
        wr(A_EN, 32'h0000_0003);
        wr(A_DIS, 32'h0000_0030);
        rd(A_MASK, d); chk("R2 mask", d, 32'h0000_00C3);
        wr(A_DIS, 32'hFFFF_FFFF);
        rd(A_MASK, d); chk("R2 mask cleared", d, 32'h0);
    endtask

    task automatic t_prio();
        logic [31:0] d;
        wr(3, 32'h2); wr(5, 32'h5); wr(9, 32'h5);
        wr(A_EN, (32'h1 << 3) | (32'h1 << 5) | (32'h1 << 9));
        src[3] = 1; src[5] = 1; src[9] = 1;
        idle(6);
        chk("R3 irq", {31'b0, irq}, 32'h1);
        rd(A_ACK, d); chk("R3 winner tie low index", d, 32'h105);
        chk("R4 irq drop", {31'b0, irq}, 32'h0);
        rd(A_STAT, d); chk("R4 status", d, 32'd5);
        idle(6);
        chk("R5 equal priority waits", {31'b0, irq}, 32'h0);
        wr(A_EOI, 32'h0);
        idle(6);
        chk("R10 level reasserts", {31'b0, irq}, 32'h1);
        rd(A_ACK, d); chk("R10 level vector", d, 32'h105);
        cleanup();
    endtask

    task automatic t_nest();
        logic [31:0] d;
        wr(2, 32'h1); wr(7, 32'h4); wr(12, 32'h4);
        wr(A_EN, (32'h1 << 2) | (32'h1 << 7) | (32'h1 << 12));
        src[2] = 1; idle(6);
        rd(A_ACK, d); chk("R5 first level", d, 32'h102);
        src[12] = 1; idle(6);
        chk("R5 preempt irq", {31'b0, irq}, 32'h1);
        rd(A_ACK, d); chk("R5 preempt vector", d, 32'h10C);
        rd(A_STAT, d); chk("R5 status nested", d, 32'd12);
        src[7] = 1; idle(6);
        chk("R5 equal blocked", {31'b0, irq}, 32'h0);
        wr(A_EOI, 32'hFFFF_FFFF);
        rd(A_STAT, d); chk("R6 outer status", d, 32'd2);
        idle(6);
        chk("R6 irq after pop", {31'b0, irq}, 32'h1);
        rd(A_ACK, d); chk("R3 tie after pop", d, 32'h107);
        cleanup();
    endtask

    task automatic t_spur();
        logic [31:0] d;
        rd(A_ACK, d); chk("R7 empty spurious", d, SPV);
        rd(A_STAT, d); chk("R7 status empty", d, 32'h0);
        wr(6, 32'h3); wr(8, 32'h2);
        wr(A_EN, (32'h1 << 6) | (32'h1 << 8));
        src[6] = 1; idle(6);
        rd(A_ACK, d); chk("R7 setup", d, 32'h106);
        rd(A_ACK, d); chk("R7 nested spurious", d, SPV);
        rd(A_STAT, d); chk("R7 status after spurious", d, 32'h0);
        src[8] = 1; idle(6);
        chk("R7 level kept", {31'b0, irq}, 32'h0);
        wr(A_EOI, 32'h0); idle(6);
        chk("R7 irq after pop", {31'b0, irq}, 32'h1);
        cleanup();
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(4, 32'h13);
        wr(A_EN, 32'h1 << 4);
        @(negedge clk) src[4] = 1;
        @(negedge clk) src[4] = 0;
        idle(6);
        chk("R8 pulse latched", {31'b0, irq}, 32'h1);
        rd(A_ACK, d); chk("R8 edge vector", d, 32'h104);
        wr(A_EOI, 32'h0); idle(6);
        chk("R8 ack clears latch", {31'b0, irq}, 32'h0);
        @(negedge clk) src[4] = 1;
        @(negedge clk) src[4] = 0;
        idle(6);
        chk("R9 latched before clear", {31'b0, irq}, 32'h1);
        wr(A_CLR, 32'h1 << 4); idle(3);
        chk("R9 cleared irq", {31'b0, irq}, 32'h0);
        rd(A_ACK, d); chk("R9 cleared vector", d, SPV);
        cleanup();
    endtask

    task automatic t_ext();
        logic [31:0] d;
        wr(1, 32'h22); wr(30, 32'h22); wr(31, 32'h33);
        rd(1, d);  chk("R11 internal sense kept", d, 32'h02);
        rd(30, d); chk("R11 external sense taken", d, 32'h22);
        src[30] = 1; src[31] = 1; idle(6);
        wr(A_EN, (32'h1 << 1) | (32'h1 << 30) | (32'h1 << 31));
        idle(4);
        chk("R11 all idle", {31'b0, irq}, 32'h0);
        src[30] = 0; idle(6);
        chk("R11 low level irq", {31'b0, irq}, 32'h1);
        rd(A_ACK, d); chk("R11 low level vector", d, 32'h11E);
        src[30] = 1; wr(A_EOI, 32'h0); idle(6);
        src[31] = 0; idle(6);
        chk("R11 falling irq", {31'b0, irq}, 32'h1);
        rd(A_ACK, d); chk("R11 falling vector", d, 32'h11F);
        wr(A_EOI, 32'h0); idle(6);
        chk("R11 falling consumed", {31'b0, irq}, 32'h0);
        cleanup();
    endtask

    task automatic t_unlock();
        logic [31:0] d;
        for (int k = 0; k < 8; k++) wr(16 + k, 32'(k));
        wr(A_EN, 32'h00FF_0000);
        for (int k = 0; k < 8; k++) begin
            src[16 + k] = 1; idle(6);
            rd(A_ACK, d); chk("R12 fill level", d, 32'h110 + 32'(k));
        end
        idle(6);
        chk("R12 full quiet", {31'b0, irq}, 32'h0);
        rd(A_ACK, d); chk("R7 full spurious", d, SPV);
        for (int k = 0; k < 8; k++) wr(A_EOI, 32'h0);
        rd(A_STAT, d); chk("R12 status empty", d, 32'h0);
        idle(6);
        chk("R12 irq again", {31'b0, irq}, 32'h1);
        rd(A_ACK, d); chk("R12 top winner", d, 32'h117);
        cleanup();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_mask();
        t_prio();
        t_nest();
        t_spur();
        t_edge();
        t_ext();
        t_unlock();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule